// File: doc/BRIEF.md
# Validity-Gated Serial Output Buffer

This block turns channel bytes held in a speech memory into the serial bit streams of eight output lines. A frame spans 1024 cycles of one bit-rate clock running at the fastest line rate (8192 kbit/s). Lines at slower rates hold each bit for two or four clocks. The buffer reads one connection-memory word every four clocks. That word supplies a speech-memory address and an inhibit flag in its most significant bit. One cycle later the buffer reads the addressed byte. It parks that byte in a per-line shadow register one time slot before it is needed, so each line shifts out whole bytes MSB first without gaps.

There are 256 output channels, and each has its own connection word. A channel whose inhibit flag is set leaves its line undriven for exactly that channel's slot. A two-bit mode input picks how the 256 channels are spread over the lines. The connection and speech memories sit outside the block. Both are synchronous read ports with one cycle of latency.

Top module: `obuf_serial_out`

## Requirements
- R1: While `rst_n` is low, `line_oe` and `line_sdo` are all zero.
- R2: In mode 2'b00, all eight lines run at 2048 kbit/s. Each line has 32 slots of 32 clocks, and each bit is held 4 clocks. The line carries channel `line*32 + slot`, MSB first.
- R3: In mode 2'b01, lines 0 to 3 run at 4096 kbit/s. Each line has 64 slots of 16 clocks, and each bit is held 2 clocks. The line carries channel `line*64 + slot`.
- R4: In mode 2'b10, lines 0 and 1 run at 8192 kbit/s. Each line has 128 slots of 8 clocks, and each bit is held 1 clock. The line carries channel `line*128 + slot`.
- R5: In mode 2'b11, the lines run at mixed rates. Lines 0 and 1 run as in R3 and carry channel `line*64 + slot`. Lines 2 to 5 run as in R2 and carry channel `128 + (line-2)*32 + slot`.
- R6: A connection word is `{inhibit, speech_addr[SM_AW-1:0]}`. When inhibit is 0, the line drives bit `7 - bit_index` of the byte at `speech_addr`. When inhibit is 1, `line_oe` is low for that slot only.
- R7: Whenever a line's `line_oe` is low, its `line_sdo` is 0.
- R8: `line_oe` of a line changes only at that line's slot boundaries, so it holds for a whole slot of at least 8 clocks. The one exception is a frame restart.
- R9: Lines that the selected mode does not use keep `line_oe` low.
- R10: After reset, slot 0 of the first frame is undriven on every line, because nothing has been prefetched for it.
- R11: `fsync` high at a clock edge makes the next cycle frame position 0. Without `fsync`, the position wraps after 1023. In every cycle at position 0, `cm_addr` is 1, which is the prefetch of slot 1 for line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock at the fastest line rate |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame restart strobe |
| mode | input | 2 | Channel-to-line arrangement; held stable outside reset |
| cm_addr | output | 8 | Connection-memory read address (channel index) |
| cm_rdata | input | SM_AW+1 | Connection word, one cycle after the address |
| sm_addr | output | SM_AW | Speech-memory read address |
| sm_rdata | input | 8 | Speech byte, one cycle after the address |
| line_sdo | output | 8 | Serial data, one bit per line |
| line_oe | output | 8 | Per-line drive enable, high drives |

## Verification
The bench builds the block with its default `SM_AW = 8`. The speech memory therefore has 256 bytes and the whole 256-channel space fits in memory models inside the bench. Each of the four modes is run for three complete frames, and every line is compared in every clock against an arithmetic model of slot, bit index and channel. This covers every channel, every bit position and every slot boundary. Further runs cover inhibit on every channel, drive on every channel, and a frame restart in mid-frame.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
    localparam int LINES    = 8;
    localparam int LINE_W   = $clog2(LINES);
    localparam int BYTE_W   = 8;
    localparam int CH_W     = 8;
    localparam int POS_W    = 10;
    localparam int PH_W     = 2;
    localparam int GRP_W    = POS_W - PH_W;
    localparam int SLOT_LO_W = 5;

    typedef enum logic [1:0] {
        OM_8X2M  = 2'b00,
        OM_4X4M  = 2'b01,
        OM_2X8M  = 2'b10,
        OM_MIXED = 2'b11
    } omode_e;

    // log2 of clocks per bit
    typedef enum logic [1:0] {
        RATE_8M = 2'd0,
        RATE_4M = 2'd1,
        RATE_2M = 2'd2
    } rate_e;

    function automatic rate_e rate_of(omode_e m, logic [LINE_W-1:0] ln);
        rate_e r;
        case (m)
            OM_8X2M: r = RATE_2M;
            OM_4X4M: r = RATE_4M;
            OM_2X8M: r = RATE_8M;
            default: r = (ln < 3'd2) ? RATE_4M : RATE_2M;
        endcase
        return r;
    endfunction

    function automatic logic line_live(omode_e m, logic [LINE_W-1:0] ln);
        logic v;
        case (m)
            OM_8X2M: v = 1'b1;
            OM_4X4M: v = (ln < 3'd4);
            OM_2X8M: v = (ln < 3'd2);
            default: v = (ln < 3'd6);
        endcase
        return v;
    endfunction
endpackage

// File: rtl/obuf_frame_timer.sv
module obuf_frame_timer
    import obuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    output logic [POS_W-1:0]     pos_o,
    output logic [SLOT_LO_W-1:0] nxt_lo_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (fsync) tmr_d.pos = '0;
        else       tmr_d.pos = tmr_q.pos + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign pos_o    = tmr_q.pos;
    assign nxt_lo_o = tmr_d.pos[SLOT_LO_W-1:0];
endmodule

// File: rtl/obuf_fetch_map.sv
module obuf_fetch_map
    import obuf_pkg::*;
(
    input  omode_e             mode,
    input  logic [GRP_W-1:0]   grp,
    output logic [CH_W-1:0]    ch_o,
    output logic [LINE_W-1:0]  line_o
);
    logic [2:0] sub;
    logic [4:0] blk;
    logic [4:0] blk_nx;
    logic [4:0] s5_nx;
    logic [5:0] s6_nx;
    logic [6:0] s7_nx;
    logic [2:0] slow_idx;

    always_comb begin
        sub      = grp[2:0];
        blk      = grp[7:3];
        blk_nx   = blk + 5'd1;
        s5_nx    = grp[7:3] + 5'd1;
        s6_nx    = grp[7:2] + 6'd1;
        s7_nx    = grp[7:1] + 7'd1;
        slow_idx = sub - 3'd2;
        ch_o     = '0;
        line_o   = '0;
        case (mode)
            OM_8X2M: begin
                line_o = grp[2:0];
                ch_o   = {grp[2:0], s5_nx};
            end
            OM_4X4M: begin
                line_o = {1'b0, grp[1:0]};
                ch_o   = {grp[1:0], s6_nx};
            end
            OM_2X8M: begin
                line_o = {2'b00, grp[0]};
                ch_o   = {grp[0], s7_nx};
            end
            default: begin
                if (sub < 3'd2) begin
                    line_o = {2'b00, sub[0]};
                    ch_o   = {1'b0, sub[0], blk, 1'b1};
                end else if (sub >= 3'd6) begin
                    line_o = {2'b00, sub[0]};
                    ch_o   = {1'b0, sub[0], blk_nx, 1'b0};
                end else begin
                    line_o = sub;
                    ch_o   = {1'b1, slow_idx[1:0], blk_nx};
                end
            end
        endcase
    end
endmodule

// File: rtl/obuf_line_ser.sv
module obuf_line_ser
    import obuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  rate_e                rate,
    input  logic [SLOT_LO_W-1:0] nxt_lo,
    input  logic                 wr_en,
    input  logic                 wr_ok,
    input  logic [BYTE_W-1:0]    wr_byte,
    output logic                 bit_o,
    output logic                 drv_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] shadow;
        logic              shadow_ok;
        logic [BYTE_W-1:0] shreg;
        logic              drv;
    } ser_t;

    ser_t ser_d, ser_q;
    logic load;
    logic step;

    always_comb begin
        case (rate)
            RATE_8M: begin load = (nxt_lo[2:0] == 3'd0); step = 1'b1;                end
            RATE_4M: begin load = (nxt_lo[3:0] == 4'd0); step = (nxt_lo[0] == 1'b0);   end
            default: begin load = (nxt_lo[4:0] == 5'd0); step = (nxt_lo[1:0] == 2'd0); end
        endcase

        ser_d = ser_q;
        if (wr_en) begin
            ser_d.shadow    = wr_byte;
            ser_d.shadow_ok = wr_ok;
        end
        if (load) begin
            ser_d.shreg = ser_q.shadow;
            ser_d.drv   = ser_q.shadow_ok;
        end else if (step) begin
            ser_d.shreg = {ser_q.shreg[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign bit_o = ser_q.shreg[BYTE_W-1];
    assign drv_o = ser_q.drv;
endmodule

// File: rtl/obuf_serial_out.sv
module obuf_serial_out
    import obuf_pkg::*;
#(
    parameter int SM_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic [1:0]         mode,
    output logic [CH_W-1:0]    cm_addr,
    input  logic [SM_AW:0]     cm_rdata,
    output logic [SM_AW-1:0]   sm_addr,
    input  logic [BYTE_W-1:0]  sm_rdata,
    output logic [LINES-1:0]   line_sdo,
    output logic [LINES-1:0]   line_oe
);
    localparam logic [PH_W-1:0] PH_CM = 2'd1;
    localparam logic [PH_W-1:0] PH_SM = 2'd2;

    typedef struct packed {
        logic              ok;
        logic [LINE_W-1:0] line;
    } pipe_t;

    omode_e                 mode_e;
    logic [POS_W-1:0]       pos;
    logic [SLOT_LO_W-1:0]   nxt_lo;
    logic [LINE_W-1:0]      fetch_line;
    logic [PH_W-1:0]        ph;
    pipe_t                  pipe_d, pipe_q;

    assign mode_e = omode_e'(mode);
    assign ph     = pos[PH_W-1:0];

    obuf_frame_timer u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .pos_o    (pos),
        .nxt_lo_o (nxt_lo)
    );

    obuf_fetch_map u_map (
        .mode   (mode_e),
        .grp    (pos[POS_W-1:PH_W]),
        .ch_o   (cm_addr),
        .line_o (fetch_line)
    );

    assign sm_addr = cm_rdata[SM_AW-1:0];

    always_comb begin
        pipe_d = pipe_q;
        if (ph == PH_CM) begin
            pipe_d.ok   = ~cm_rdata[SM_AW];
            pipe_d.line = fetch_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic drv;
        logic sbit;
        logic live;
        logic wr;

        assign live = line_live(mode_e, LINE_W'(i));
        assign wr   = (ph == PH_SM) && (pipe_q.line == LINE_W'(i));

        obuf_line_ser u_ser (
            .clk     (clk),
            .rst_n   (rst_n),
            .rate    (rate_of(mode_e, LINE_W'(i))),
            .nxt_lo  (nxt_lo),
            .wr_en   (wr),
            .wr_ok   (pipe_q.ok),
            .wr_byte (sm_rdata),
            .bit_o   (sbit),
            .drv_o   (drv)
        );

        assign line_oe[i]  = drv & live;
        assign line_sdo[i] = drv & live & sbit;
    end
endmodule

// File: rtl/obuf_serial_out_chk.sv
module obuf_serial_out_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fsync,
    input logic [1:0] mode,
    input logic [7:0] cm_addr,
    input logic [7:0] line_sdo,
    input logic [7:0] line_oe
);
    logic [7:0] live_mask;
    logic       fs_prev_q;

    always_comb begin
        case (mode)
            2'b00:   live_mask = 8'hFF;
            2'b01:   live_mask = 8'h0F;
            2'b10:   live_mask = 8'h03;
            default: live_mask = 8'h3F;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_prev_q <= 1'b0;
        else        fs_prev_q <= fsync;
    end

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sdo & ~line_oe) == 8'h00); // R7

    AST_UNUSED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe & ~live_mask) == 8'h00); // R9

    AST_RESTART_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> cm_addr == 8'd1); // R11

    for (genvar i = 0; i < 8; i++) begin : g_hold
        logic       oe_prev_q;
        logic [3:0] run_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oe_prev_q <= 1'b0;
                run_q     <= '0;
            end else begin
                oe_prev_q <= line_oe[i];
                if (line_oe[i] != oe_prev_q) run_q <= '0;
                else if (run_q != 4'hF)      run_q <= run_q + 4'd1;
            end
        end

        AST_OE_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((line_oe[i] != oe_prev_q) && !fs_prev_q) |-> run_q >= 4'd7); // R8
    end
endmodule

bind obuf_serial_out obuf_serial_out_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .mode     (mode),
    .cm_addr  (cm_addr),
    .line_sdo (line_sdo),
    .line_oe  (line_oe)
);

// File: tb/tb_obuf_serial_out.sv
module tb_obuf_serial_out;
    localparam int SM_AW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fsync = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [7:0]       cm_addr;
    logic [SM_AW:0]   cm_rdata;
    logic [SM_AW-1:0] sm_addr;
    logic [7:0]       sm_rdata;
    logic [7:0]       line_sdo;
    logic [7:0]       line_oe;

    logic [SM_AW:0]   cm_mem [256];
    logic [7:0]       sm_mem [256];

    int checks = 0;
    int errors = 0;
    int tb_pos = 0;
    int tb_frm = 0;
    bit quiet  = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    obuf_serial_out #(.SM_AW(SM_AW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .mode     (mode),
        .cm_addr  (cm_addr),
        .cm_rdata (cm_rdata),
        .sm_addr  (sm_addr),
        .sm_rdata (sm_rdata),
        .line_sdo (line_sdo),
        .line_oe  (line_oe)
    );

    // synchronous read memories and the frame position model
    always @(posedge clk) begin
        cm_rdata <= cm_mem[cm_addr];
        sm_rdata <= sm_mem[sm_addr];
        if (!rst_n) begin
            tb_pos <= 0;
            tb_frm <= 0;
        end else if (fsync || tb_pos == 1023) begin
            tb_pos <= 0;
            tb_frm <= tb_frm + 1;
        end else begin
            tb_pos <= tb_pos + 1;
        end
    end

    task automatic check_val(string tag, string what, int ln, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s line %0d mode %0d pos %0d frame %0d: actual %0d expected %0d",
                     tag, what, ln, mode, tb_pos, tb_frm, act, exp);
        end
    endtask

    task automatic fill(int seed, int inh_kind);
        for (int c = 0; c < 256; c++) begin
            logic inh;
            sm_mem[c] = 8'(((c * 29) + 71 + seed * 13) ^ (seed * 5));
            case (inh_kind)
                1:       inh = 1'b1;
                2:       inh = 1'b0;
                default: inh = (((c * 5) + seed) % 7) == 3;
            endcase
            cm_mem[c] = {inh, 8'((c * 13) + (seed * 7) + 3)};
        end
    endtask

    task automatic check_lines();
        for (int ln = 0; ln < 8; ln++) begin
            int    kl;
            int    ch;
            int    slot;
            int    bt;
            bit    act;
            bit    eo;
            bit    es;
            string otag;
            string dtag;
            act = 1'b1;
            case (mode)
                2'd0:    begin kl = 2; dtag = "R2"; end
                2'd1:    begin kl = 1; act = (ln < 4); dtag = "R3"; end
                2'd2:    begin kl = 0; act = (ln < 2); dtag = "R4"; end
                default: begin kl = (ln < 2) ? 1 : 2; act = (ln < 6); dtag = "R5"; end
            endcase
            slot = tb_pos >> (3 + kl);
            bt   = (tb_pos >> kl) & 7;
            case (mode)
                2'd0:    ch = ln * 32 + slot;
                2'd1:    ch = ln * 64 + slot;
                2'd2:    ch = ln * 128 + slot;
                default: ch = (ln < 2) ? (ln * 64 + slot) : (128 + (ln - 2) * 32 + slot);
            endcase
            if (!act) ch = 0;
            eo = act && !(tb_frm == 0 && slot == 0) && !cm_mem[ch][SM_AW];
            es = eo ? sm_mem[cm_mem[ch][SM_AW-1:0]][7 - bt] : 1'b0;
            if (!act)                        otag = "R9";
            else if (tb_frm == 0 && slot == 0) otag = "R10";
            else                             otag = "R6 R8";  // enable per slot, constant over slot
            check_val(otag, "oe", ln, int'(line_oe[ln]), int'(eo));
            check_val(eo ? dtag : "R7", "sdo", ln, int'(line_sdo[ln]), int'(es));
        end
    endtask

    task automatic start(logic [1:0] m);
        rst_n = 1'b0;
        fsync = 1'b0;
        mode  = m;
        repeat (3) begin
            @(negedge clk);
            check_val("R1", "oe in reset", 0, int'(line_oe), 0);
            check_val("R1", "sdo in reset", 0, int'(line_sdo), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic run(int ncyc, int rs_frm, int rs_pos);
        for (int i = 0; i < ncyc; i++) begin
            if (quiet && tb_pos >= 32) quiet = 1'b0;
            if (!quiet) check_lines();
            if (tb_pos == 0) check_val("R11", "cm_addr at frame start", 0, int'(cm_addr), 1);
            fsync = (tb_pos == 1023) || (tb_frm == rs_frm && tb_pos == rs_pos);
            if (fsync && tb_pos != 1023) quiet = 1'b1;
            @(negedge clk);
        end
        fsync = 1'b0;
    endtask

    initial begin
        fill(1, 0);
        @(negedge clk);
        // R2 .. R5 with a mixed inhibit pattern
        for (int m = 0; m < 4; m++) begin
            fill(m + 2, 0);
            start(2'(m));
            run(3 * 1024, -1, -1);
        end
        // R6: every channel inhibited
        fill(9, 1);
        start(2'd0);
        run(2 * 1024, -1, -1);
        // R6 and R11: every channel driven, restart in mid-frame
        fill(11, 2);
        start(2'd0);
        run(4 * 1024, 1, 500);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer", 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule